// File: doc/BRIEF.md
# Add/Subtract Unit with Condition Flags

This block is the add/subtract slice of an integer execution stage. One micro-operation arrives per cycle with an opcode, a first operand and a second operand. The second operand is either a register value or an 8-bit immediate sign-extended to the data width. The block covers four operations: plain addition, addition with the incoming carry, plain subtraction, and subtraction with the incoming borrow.

The result leaves combinationally in the same cycle. The block also works out eight condition bits: carry, a duplicated extended carry, zero, a duplicated extended zero, parity, nibble auxiliary carry, sign and signed overflow. These bits are loaded into a flags register on the clock edge, but only when the micro-op is valid, legal and has its flag-write enable set. The caller owns the architectural carry and feeds it back on `carry_in`.

Top module: `arith_flag_unit`

## Requirements
- R1: With `opcode` 0 `result` is A+B, with 1 it is A+B+`carry_in`, with 2 it is A−B, and with 3 it is A−B−`carry_in`, all modulo 2^W. `carry_in` has no effect for opcodes 0 and 2.
- R2: When `imm_sel`=1, B is `imm8` sign-extended to W bits. Otherwise B is `src_b`.
- R3: The carry bits `flags_q[0]` and `flags_q[1]` both load the carry out of bit W−1 for opcodes 0 and 1. For opcodes 2 and 3 they both load the unsigned borrow of the whole subtraction.
- R4: The zero bits `flags_q[2]` and `flags_q[3]` both load 1 exactly when the W-bit result is zero.
- R5: `flags_q[6]` loads bit W−1 of the result. `flags_q[7]` loads 1 when the signed two's-complement result does not fit in W bits.
- R6: `flags_q[5]` loads the carry out of bit 3 for additions, or the borrow out of bit 4 into bit 3 for subtractions.
- R7: `flags_q[4]` loads 1 when bits 7:0 of the result hold an even number of ones.
- R8: `flags_q` changes on a rising clock edge only when `op_valid`, `flags_we` and a legal opcode are all present at that edge. Otherwise all eight bits keep their values.
- R9: Opcodes 4 to 7 drive `result` to zero and never load the flags.
- R10: An active-low `rst_n` clears `flags_q` to all zeros at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | A micro-op is present this cycle |
| opcode | input | 3 | 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow |
| imm_sel | input | 1 | Use the immediate as the second operand |
| src_a | input | W | First operand |
| src_b | input | W | Second register operand |
| imm8 | input | 8 | Signed immediate |
| carry_in | input | 1 | Incoming carry/borrow flag |
| flags_we | input | 1 | This micro-op updates the flags |
| result | output | W | Combinational result |
| flags_q | output | 8 | Flags: 0 CF, 1 ECF, 2 ZF, 3 EZF, 4 PF, 5 AF, 6 SF, 7 OF |

## Verification
The assertions assume that W is at least 9, so that the immediate extension and the bit-4 auxiliary carry both exist. They also assume that `opcode`, `imm_sel` and the operands are stable around each rising edge. The stimulus changes inputs only on falling edges and holds reset low from time zero, so every flag load sees settled operands. Both the random and the directed micro-ops cover all eight opcode values, and the stimulus toggles `flags_we` and `op_valid` freely. This lets the hold and illegal-opcode rules be exercised alongside the normal loads.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

  localparam logic [2:0] OPC_ADD = 3'd0;
  localparam logic [2:0] OPC_ADC = 3'd1;
  localparam logic [2:0] OPC_SUB = 3'd2;
  localparam logic [2:0] OPC_SBB = 3'd3;

  typedef struct packed {
    logic ovf;
    logic sgn;
    logic aux;
    logic par;
    logic zero_x;
    logic zero;
    logic carry_x;
    logic carry;
  } flags_t;

  function automatic logic even_ones8(input logic [7:0] v);
    return ~^v;
  endfunction

  function automatic logic opc_legal(input logic [2:0] opc);
    return opc[2] == 1'b0;
  endfunction

  function automatic logic opc_is_sub(input logic [2:0] opc);
    return opc[1];
  endfunction

  function automatic logic opc_uses_carry(input logic [2:0] opc);
    return opc[0];
  endfunction

endpackage

// File: rtl/alu_operand_sel.sv
module alu_operand_sel #(
  parameter int W = 32
) (
  input  logic         imm_sel,
  input  logic [W-1:0] src_b,
  input  logic [7:0]   imm8,
  output logic [W-1:0] opnd_b
);
  localparam int EXT = W - 8;

  logic [W-1:0] imm_ext;

  generate
    if (EXT > 0) begin : g_ext
      assign imm_ext = {{EXT{imm8[7]}}, imm8};
    end else begin : g_noext
      assign imm_ext = imm8[W-1:0];
    end
  endgenerate

  assign opnd_b = imm_sel ? imm_ext : src_b;
endmodule

// File: rtl/alu_addsub_core.sv
module alu_addsub_core
  import alu_flags_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [2:0]   opcode,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic         carry_in,
  output logic [W-1:0] sum,
  output logic         carry_out,
  output logic         aux_out,
  output logic         ovf_out,
  output logic         legal
);
  localparam int MSB = W - 1;

  logic         is_sub;
  logic         cin_eff;
  logic [W:0]   wide;

  function automatic logic [W:0] wide_addsub(input logic [W-1:0] a,
                                             input logic [W-1:0] b,
                                             input logic c, input logic sub);
    logic [W:0] ea;
    logic [W:0] eb;
    logic [W:0] ec;
    ea = {1'b0, a};
    eb = {1'b0, b};
    ec = {{W{1'b0}}, c};
    return sub ? (ea - eb - ec) : (ea + eb + ec);
  endfunction

  function automatic logic signed_ovf(input logic a_s, input logic b_s,
                                      input logic r_s, input logic sub);
    return sub ? ((a_s != b_s) && (r_s != a_s))
               : ((a_s == b_s) && (r_s != a_s));
  endfunction

  assign legal   = opc_legal(opcode);
  assign is_sub  = opc_is_sub(opcode);
  assign cin_eff = opc_uses_carry(opcode) & carry_in;
  assign wide    = wide_addsub(opnd_a, opnd_b, cin_eff, is_sub);

  assign sum       = legal ? wide[MSB:0] : '0;
  assign carry_out = wide[W];
  assign aux_out   = wide[4] ^ opnd_a[4] ^ opnd_b[4];
  assign ovf_out   = signed_ovf(opnd_a[MSB], opnd_b[MSB], wide[MSB], is_sub);
endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
  import alu_flags_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] sum,
  input  logic         carry_out,
  input  logic         aux_out,
  input  logic         ovf_out,
  output flags_t       next_flags
);
  logic is_zero;

  assign is_zero = (sum == '0);

  always_comb begin
    next_flags         = '0;
    next_flags.carry   = carry_out;
    next_flags.carry_x = carry_out;
    next_flags.zero    = is_zero;
    next_flags.zero_x  = is_zero;
    next_flags.par     = even_ones8(sum[7:0]);
    next_flags.aux     = aux_out;
    next_flags.sgn     = sum[W-1];
    next_flags.ovf     = ovf_out;
  end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_flags_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  flags_t d,
  output flags_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/arith_flag_unit.sv
module arith_flag_unit
  import alu_flags_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [2:0]   opcode,
  input  logic         imm_sel,
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  input  logic [7:0]   imm8,
  input  logic         carry_in,
  input  logic         flags_we,
  output logic [W-1:0] result,
  output logic [7:0]   flags_q
);
  logic [W-1:0] opnd_b;
  logic         carry_out;
  logic         aux_out;
  logic         ovf_out;
  logic         legal;
  logic         flag_wr;
  flags_t       next_flags;
  flags_t       flags_r;

  alu_operand_sel #(.W(W)) u_sel (
    .imm_sel (imm_sel),
    .src_b   (src_b),
    .imm8    (imm8),
    .opnd_b  (opnd_b)
  );

  alu_addsub_core #(.W(W)) u_core (
    .opcode    (opcode),
    .opnd_a    (src_a),
    .opnd_b    (opnd_b),
    .carry_in  (carry_in),
    .sum       (result),
    .carry_out (carry_out),
    .aux_out   (aux_out),
    .ovf_out   (ovf_out),
    .legal     (legal)
  );

  alu_flag_gen #(.W(W)) u_gen (
    .sum        (result),
    .carry_out  (carry_out),
    .aux_out    (aux_out),
    .ovf_out    (ovf_out),
    .next_flags (next_flags)
  );

  assign flag_wr = op_valid & flags_we & legal;

  alu_flag_reg u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (flag_wr),
    .d     (next_flags),
    .q     (flags_r)
  );

  assign flags_q = flags_r;
endmodule

// File: rtl/alu_flags_checker.sv
module alu_flags_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [2:0]   opcode,
  input logic         flag_wr,
  input logic [7:0]   next_flags,
  input logic [W-1:0] result,
  input logic [7:0]   flags_q
);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_wr |=> flags_q == $past(flags_q));

  a_r8_load: assert property (@(posedge clk) disable iff (!rst_n)
    flag_wr |=> flags_q == $past(next_flags));

  a_r3_carry_dup: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q[0] == flags_q[1]);

  a_r4_zero_dup: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q[2] == flags_q[3]);

  a_r4_zero_set: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && result == '0) |=> flags_q[2]);

  a_r5_sign: assert property (@(posedge clk) disable iff (!rst_n)
    flag_wr |=> flags_q[6] == $past(result[W-1]));

  a_r9_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    opcode[2] |-> (result == '0) && !flag_wr);

  a_r10_reset: assert property (@(posedge clk)
    !rst_n |-> flags_q == 8'h00);
endmodule

bind arith_flag_unit alu_flags_checker #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .opcode     (opcode),
  .flag_wr    (flag_wr),
  .next_flags (next_flags),
  .result     (result),
  .flags_q    (flags_q)
);

// File: tb/arith_flag_unit_test.sv
module arith_flag_unit_test;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         op_valid = 1'b0;
  logic [2:0]   opcode = '0;
  logic         imm_sel = 1'b0;
  logic [W-1:0] src_a = '0;
  logic [W-1:0] src_b = '0;
  logic [7:0]   imm8 = '0;
  logic         carry_in = 1'b0;
  logic         flags_we = 1'b0;
  logic [W-1:0] result;
  logic [7:0]   flags_q;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [7:0] model_flags = 8'h00;
  logic [7:0] sb_q[$];

  always #5 clk = ~clk;

  arith_flag_unit #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
    .imm_sel(imm_sel), .src_a(src_a), .src_b(src_b), .imm8(imm8),
    .carry_in(carry_in), .flags_we(flags_we), .result(result),
    .flags_q(flags_q)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic check_bit(input string req, input string name,
                           input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, name, act, exp);
    end
  endtask

  // Reference written from the requirements with wide signed/unsigned math.
  task automatic ref_op(input logic [2:0] op, input logic [W-1:0] a,
                        input logic [W-1:0] b, input logic cin,
                        output logic [W-1:0] r, output logic [7:0] f,
                        output bit ok);
    longint unsigned ua, ub, full;
    longint sa, sb, sr, c;
    logic cf, af, of_b, zf, pf;
    ok = (op < 3'd4);
    c  = (op == 3'd1 || op == 3'd3) ? longint'(cin) : 0;
    ua = longint'(a);
    ub = longint'(b);
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    if (op == 3'd0 || op == 3'd1) begin
      full = ua + ub + longint'(c);
      cf   = full >= 64'h1_0000_0000;
      af   = ((ua & 15) + (ub & 15) + longint'(c)) > 15;
      sr   = sa + sb + c;
    end else begin
      full = ua - ub - longint'(c);
      cf   = ua < ub + longint'(c);
      af   = (ua & 15) < (ub & 15) + longint'(c);
      sr   = sa - sb - c;
    end
    of_b = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
    r    = ok ? full[W-1:0] : '0;
    zf   = (r == '0);
    pf   = ($countones(r[7:0]) % 2) == 0;
    f    = {of_b, r[W-1], af, pf, zf, zf, cf, cf};
  endtask

  task automatic drive(input logic [2:0] op, input logic isel,
                       input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [7:0] imm, input logic cin,
                       input logic we, input logic vld);
    logic [W-1:0] exp_r, beff;
    logic [7:0]   exp_f;
    bit           ok;
    @(negedge clk);
    opcode = op; imm_sel = isel; src_a = a; src_b = b; imm8 = imm;
    carry_in = cin; flags_we = we; op_valid = vld;
    beff = isel ? {{(W-8){imm[7]}}, imm} : b;
    ref_op(op, a, beff, cin, exp_r, exp_f, ok);
    #1;
    checks++;
    if (result !== exp_r) begin
      failures++;
      if (!ok)       $display("FAIL R9 result actual=%h expected=%h", result, exp_r);
      else if (isel) $display("FAIL R2 result actual=%h expected=%h", result, exp_r);
      else           $display("FAIL R1 result actual=%h expected=%h", result, exp_r);
    end
    if (ok && we && vld) model_flags = exp_f;
    sb_q.push_back(model_flags);
  endtask

  // Monitor: compares the loaded flags just after each rising edge (R8 hold).
  always @(posedge clk) begin
    #2;
    if (sb_q.size() > 0) begin
      logic [7:0] e;
      e = sb_q.pop_front();
      check_bit("R3", "CF",  flags_q[0], e[0]);
      check_bit("R3", "ECF", flags_q[1], e[1]);
      check_bit("R4", "ZF",  flags_q[2], e[2]);
      check_bit("R4", "EZF", flags_q[3], e[3]);
      check_bit("R7", "PF",  flags_q[4], e[4]);
      check_bit("R6", "AF",  flags_q[5], e[5]);
      check_bit("R5", "SF",  flags_q[6], e[6]);
      check_bit("R5", "OF",  flags_q[7], e[7]);
    end
  end

  initial begin
    #1_000_000;
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [W-1:0] edges [3];
    edges[0] = '0;
    edges[1] = '1;
    edges[2] = {1'b1, {(W-1){1'b0}}};
    void'($urandom(7));
    repeat (3) @(negedge clk);
    #1;
    check_bit("R10", "reset", flags_q == 8'h00, 1'b1);
    rst_n = 1'b1;

    // R3 R4 R6 R7: all-ones plus one wraps to zero.
    drive(3'd0, 0, 32'hFFFF_FFFF, 32'h1, 8'h0, 0, 1, 1);
    // R1: carry_in ignored for plain add, honoured by adc.
    drive(3'd0, 0, 32'h10, 32'h20, 8'h0, 1, 1, 1);
    drive(3'd1, 0, 32'h10, 32'h20, 8'h0, 1, 1, 1);
    // R3 borrow, R5 overflow on subtract.
    drive(3'd2, 0, 32'h0, 32'h1, 8'h0, 0, 1, 1);
    drive(3'd2, 0, 32'h8000_0000, 32'h1, 8'h0, 1, 1, 1);
    drive(3'd3, 0, 32'h5, 32'h5, 8'h0, 1, 1, 1);
    // R2: negative immediate extends.
    drive(3'd0, 1, 32'h5, 32'h1234, 8'hFF, 0, 1, 1);
    drive(3'd2, 1, 32'h5, 32'h0, 8'h80, 0, 1, 1);
    // R8: disabled write and invalid micro-op leave flags unchanged.
    drive(3'd0, 0, 32'h7FFF_FFFF, 32'h1, 8'h0, 0, 0, 1);
    drive(3'd0, 0, 32'h7FFF_FFFF, 32'h1, 8'h0, 0, 1, 0);
    drive(3'd0, 0, 32'h7FFF_FFFF, 32'h1, 8'h0, 0, 1, 1);
    // R9: illegal opcodes.
    for (int k = 4; k < 8; k++)
      drive(3'(k), 0, 32'h1, 32'h1, 8'h0, 1, 1, 1);

    // Edge operand combinations.
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++)
        for (int o = 0; o < 4; o++)
          drive(3'(o), 0, edges[i], edges[j], 8'h0, 1'(o & 1), 1, 1);

    // Random micro-ops.
    for (int n = 0; n < 600; n++)
      drive(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
            $urandom(), $urandom(), 8'($urandom()), 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 7) != 0));

    // R10: reset mid-run clears flags without a clock edge.
    drive(3'd2, 0, 32'h0, 32'h3, 8'h0, 0, 1, 1);
    @(negedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check_bit("R10", "async clear", flags_q == 8'h00, 1'b1);
    model_flags = 8'h00;
    @(negedge clk);
    rst_n = 1'b1;
    drive(3'd0, 0, 32'h1, 32'h1, 8'h0, 0, 0, 1);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule